// File: doc/BRIEF.md
# Memory Load Alignment Unit

This block sits between the load/store execute stage of a processor and a 32-bit, byte-addressed, little-endian data memory. One access is taken at a time. Each access carries a byte address, a size (byte, halfword or word), a flag that selects sign or zero extension for loads, a write flag and a store-data word. The block turns the access into one or two word-aligned memory requests with byte enables. For a load it returns the data shifted down to bit 0 and extended to 32 bits.

A halfword is naturally aligned at an even address and a word at an address that is a multiple of four. A misaligned access is handled according to a run-time mode input. The truncate mode clears the offending low address bits. The checking mode refuses the access and raises a fault without touching memory. The transparent mode performs the access at the exact address and splits it into two memory requests when the bytes cross a word boundary, merging the returned words into one result.

The memory side uses a simple one-outstanding protocol. `mem_req_o` is high for exactly one cycle per request. The memory answers each request, read or write, with a one-cycle `mem_rvalid_i` in some later cycle.

Top module: `mla_top`

## Requirements
- R1: Size code 0 is a byte, 1 a halfword, and 2 or 3 a word. A halfword with address bit 0 set, or a word with either of address bits [1:0] set, is misaligned. Under mode code 0, and under the spare code 3, a misaligned access clears those bits and performs one memory access at the truncated address.
- R2: Under mode code 1, a misaligned access issues no memory request and completes with `fault_o` high in the `done_o` cycle. Aligned accesses in this mode complete normally with `fault_o` low.
- R3: Under mode code 2, an access whose bytes stay inside one 4-byte word uses one memory request. An access that crosses a word boundary uses two requests: the lower word first, then the word at the next address (the address wraps at the top of the address space).
- R4: Load data is little-endian. The byte at the lowest accessed address appears at `load_data_o[7:0]` and the following bytes appear above it.
- R5: Byte and halfword loads are zero-extended when `req_signed_i` is 0 and sign-extended from their top bit when it is 1. Word loads ignore `req_signed_i`.
- R6: A store writes only its targeted bytes. Each memory write carries a 4-bit byte-enable mask in which bit i enables data bits [8i+7:8i] of the addressed word, and each half of a split store uses its own mask.
- R7: `done_o` is high for exactly one cycle. That cycle is the one after the final memory response, or the one after acceptance for a faulting access.
- R8: `req_ready_o` is high while idle. It is low from the cycle after an access is accepted through its `done_o` cycle.
- R9: Every memory request has address bits [1:0] equal to zero, and `mem_req_o` is high for one cycle per request.
- R10: During and right after reset, `req_ready_o` is high and `mem_req_o`, `done_o` and `fault_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Access request present |
| req_ready_o | output | 1 | Block can accept an access |
| req_addr_i | input | 32 | Byte address of the access |
| req_size_i | input | 2 | 0 byte, 1 halfword, 2/3 word |
| req_signed_i | input | 1 | Sign-extend byte and halfword loads |
| req_write_i | input | 1 | 1 store, 0 load |
| req_wdata_i | input | 32 | Store data, right-aligned |
| mode_i | input | 2 | 0/3 truncate, 1 fault, 2 transparent split |
| mem_req_o | output | 1 | One-cycle memory request strobe |
| mem_addr_o | output | 32 | Word-aligned memory address |
| mem_we_o | output | 1 | Memory request is a write |
| mem_be_o | output | 4 | Byte enables of the request |
| mem_wdata_o | output | 32 | Write data placed in byte lanes |
| mem_rvalid_i | input | 1 | Memory response strobe |
| mem_rdata_i | input | 32 | Memory read data |
| done_o | output | 1 | Access completed (one cycle) |
| fault_o | output | 1 | Completed access faulted on alignment |
| load_data_o | output | 32 | Aligned and extended load result, valid with done_o |

## Verification
Directed cases cover each alignment offset against each mode. They separate truncation, which moves the access to a different byte, from faulting, which shows up as no memory request, and from splitting, which shows up as two requests. A split at the top of the address window checks the address wrap. Signed and unsigned loads of bytes whose top bit is set separate zero extension from sign extension, and a word load with both flag values shows that the flag has no effect there. Random mixes of loads and stores over a small memory, with random response latency, compare every load result and the whole memory image after every store against a byte-level model. Untouched bytes changing, byte lanes swapped, or the wrong half of a split would all show up in that comparison.

// File: rtl/mla_pkg.sv
package mla_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ0,
    ST_WAIT0,
    ST_REQ1,
    ST_WAIT1,
    ST_DONE
  } mla_state_e;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;

  localparam logic [1:0] MD_TRUNC = 2'd0;
  localparam logic [1:0] MD_FAULT = 2'd1;
  localparam logic [1:0] MD_SPLIT = 2'd2;
endpackage

// File: rtl/mla_misalign.sv
module mla_misalign #(
  parameter int OFF_W = 2
) (
  input  logic [OFF_W-1:0] off_i,
  input  logic [1:0]       size_i,
  output logic [OFF_W-1:0] mask_o,
  output logic             mis_o
);
  logic [OFF_W:0] ones;
  int unsigned    eff;

  always_comb begin
    eff    = (int'(size_i) > OFF_W) ? OFF_W : int'(size_i);
    ones   = ({{OFF_W{1'b0}}, 1'b1} << eff) - 1'b1;
    mask_o = ones[OFF_W-1:0];
    mis_o  = |(off_i & mask_o);
  end
endmodule

// File: rtl/mla_lane_plan.sv
module mla_lane_plan
  import mla_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [1:0]         size_i,
  input  logic [1:0]         mode_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic               fault_o,
  output logic [$clog2(DATA_W/8)-1:0] off_o,
  output logic [ADDR_W-1:0]  base_o,
  output logic [ADDR_W-1:0]  next_o,
  output logic [DATA_W/8-1:0] be0_o,
  output logic [DATA_W/8-1:0] be1_o,
  output logic               two_o,
  output logic [DATA_W-1:0]  wd0_o,
  output logic [DATA_W-1:0]  wd1_o
);
  localparam int NB    = DATA_W / 8;
  localparam int OFF_W = $clog2(NB);

  logic [OFF_W-1:0]    sz_mask;
  logic                mis;
  logic [ADDR_W-1:0]   ea;
  logic [NB-1:0]       lanes;
  logic [2*NB-1:0]     span;
  logic [2*DATA_W-1:0] wide;

  mla_misalign #(.OFF_W(OFF_W)) u_mis (
    .off_i  (addr_i[OFF_W-1:0]),
    .size_i (size_i),
    .mask_o (sz_mask),
    .mis_o  (mis)
  );

  always_comb begin
    // truncate unless the transparent mode is selected
    if (mis && mode_i != MD_SPLIT)
      ea = addr_i & ~{{(ADDR_W-OFF_W){1'b0}}, sz_mask};
    else
      ea = addr_i;
    fault_o = mis && (mode_i == MD_FAULT);
    off_o   = ea[OFF_W-1:0];
    base_o  = {ea[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
    next_o  = base_o + ADDR_W'(NB);
    for (int i = 0; i < NB; i++) lanes[i] = (OFF_W'(i) <= sz_mask);
    span    = {{NB{1'b0}}, lanes} << off_o;
    be0_o   = span[NB-1:0];
    be1_o   = span[2*NB-1:NB];
    two_o   = |be1_o;
    wide    = {{DATA_W{1'b0}}, wdata_i} << {off_o, 3'b000};
    wd0_o   = wide[DATA_W-1:0];
    wd1_o   = wide[2*DATA_W-1:DATA_W];
  end
endmodule

// File: rtl/mla_load_merge.sv
module mla_load_merge
  import mla_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0]           lo_i,
  input  logic [DATA_W-1:0]           hi_i,
  input  logic [$clog2(DATA_W/8)-1:0] off_i,
  input  logic [1:0]                  size_i,
  input  logic                        signed_i,
  output logic [DATA_W-1:0]           data_o
);
  logic [2*DATA_W-1:0] wide;

  always_comb begin
    wide = {hi_i, lo_i} >> {off_i, 3'b000};
    unique case (size_i)
      SZ_BYTE: data_o = {{(DATA_W-8){signed_i & wide[7]}}, wide[7:0]};
      SZ_HALF: data_o = {{(DATA_W-16){signed_i & wide[15]}}, wide[15:0]};
      default: data_o = wide[DATA_W-1:0];
    endcase
  end
endmodule

// File: rtl/mla_top.sv
module mla_top
  import mla_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_valid_i,
  output logic                req_ready_o,
  input  logic [ADDR_W-1:0]   req_addr_i,
  input  logic [1:0]          req_size_i,
  input  logic                req_signed_i,
  input  logic                req_write_i,
  input  logic [DATA_W-1:0]   req_wdata_i,
  input  logic [1:0]          mode_i,
  output logic                mem_req_o,
  output logic [ADDR_W-1:0]   mem_addr_o,
  output logic                mem_we_o,
  output logic [DATA_W/8-1:0] mem_be_o,
  output logic [DATA_W-1:0]   mem_wdata_o,
  input  logic                mem_rvalid_i,
  input  logic [DATA_W-1:0]   mem_rdata_i,
  output logic                done_o,
  output logic                fault_o,
  output logic [DATA_W-1:0]   load_data_o
);
  localparam int NB    = DATA_W / 8;
  localparam int OFF_W = $clog2(NB);

  mla_state_e state_q, state_d;

  logic              pl_fault, pl_two;
  logic [OFF_W-1:0]  pl_off;
  logic [ADDR_W-1:0] pl_base, pl_next;
  logic [NB-1:0]     pl_be0, pl_be1;
  logic [DATA_W-1:0] pl_wd0, pl_wd1;

  logic              fault_q, two_q, we_q, sgn_q;
  logic [1:0]        size_q;
  logic [OFF_W-1:0]  off_q;
  logic [ADDR_W-1:0] base_q, next_q;
  logic [NB-1:0]     be0_q, be1_q;
  logic [DATA_W-1:0] wd0_q, wd1_q, lo_q, hi_q;

  logic accept;

  mla_lane_plan #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_plan (
    .addr_i  (req_addr_i),
    .size_i  (req_size_i),
    .mode_i  (mode_i),
    .wdata_i (req_wdata_i),
    .fault_o (pl_fault),
    .off_o   (pl_off),
    .base_o  (pl_base),
    .next_o  (pl_next),
    .be0_o   (pl_be0),
    .be1_o   (pl_be1),
    .two_o   (pl_two),
    .wd0_o   (pl_wd0),
    .wd1_o   (pl_wd1)
  );

  mla_load_merge #(.DATA_W(DATA_W)) u_merge (
    .lo_i     (lo_q),
    .hi_i     (hi_q),
    .off_i    (off_q),
    .size_i   (size_q),
    .signed_i (sgn_q),
    .data_o   (load_data_o)
  );

  assign req_ready_o = (state_q == ST_IDLE);
  assign accept      = req_valid_i && req_ready_o;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (accept) state_d = pl_fault ? ST_DONE : ST_REQ0;
      ST_REQ0:  state_d = ST_WAIT0;
      ST_WAIT0: if (mem_rvalid_i) state_d = two_q ? ST_REQ1 : ST_DONE;
      ST_REQ1:  state_d = ST_WAIT1;
      ST_WAIT1: if (mem_rvalid_i) state_d = ST_DONE;
      ST_DONE:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      fault_q <= 1'b0;
      two_q   <= 1'b0;
      we_q    <= 1'b0;
      sgn_q   <= 1'b0;
      size_q  <= '0;
      off_q   <= '0;
      base_q  <= '0;
      next_q  <= '0;
      be0_q   <= '0;
      be1_q   <= '0;
      wd0_q   <= '0;
      wd1_q   <= '0;
      lo_q    <= '0;
      hi_q    <= '0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        fault_q <= pl_fault;
        two_q   <= pl_two;
        we_q    <= req_write_i;
        sgn_q   <= req_signed_i;
        size_q  <= req_size_i;
        off_q   <= pl_off;
        base_q  <= pl_base;
        next_q  <= pl_next;
        be0_q   <= pl_be0;
        be1_q   <= pl_be1;
        wd0_q   <= pl_wd0;
        wd1_q   <= pl_wd1;
        hi_q    <= '0;
      end
      if (state_q == ST_WAIT0 && mem_rvalid_i) lo_q <= mem_rdata_i;
      if (state_q == ST_WAIT1 && mem_rvalid_i) hi_q <= mem_rdata_i;
    end
  end

  always_comb begin
    mem_req_o   = (state_q == ST_REQ0) || (state_q == ST_REQ1);
    mem_we_o    = we_q;
    mem_addr_o  = (state_q == ST_REQ1) ? next_q : base_q;
    mem_be_o    = (state_q == ST_REQ1) ? be1_q : be0_q;
    mem_wdata_o = (state_q == ST_REQ1) ? wd1_q : wd0_q;
    done_o      = (state_q == ST_DONE);
    fault_o     = (state_q == ST_DONE) && fault_q;
  end

  p_fault_no_mem_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && pl_fault) |=> (done_o && fault_o && !mem_req_o));

  p_second_next_word_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && state_q == ST_REQ1) |-> (mem_addr_o == base_q + ADDR_W'(NB)));

  p_be_nonzero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> (mem_be_o != '0));

  p_done_after_rsp_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_rvalid_i && ((state_q == ST_WAIT0 && !two_q) || state_q == ST_WAIT1)) |=> done_o);

  p_done_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_busy_after_accept_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> !req_ready_o);

  p_word_addr_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> (mem_addr_o[OFF_W-1:0] == '0));

  p_req_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |=> !mem_req_o);
endmodule

// File: tb/sim_mla_top.sv
module sim_mla_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic [1:0]  req_size = '0;
  logic        req_signed = 1'b0;
  logic        req_write = 1'b0;
  logic [31:0] req_wdata = '0;
  logic [1:0]  mode = '0;
  logic        mem_req, mem_we, mem_rvalid, done, fault;
  logic [31:0] mem_addr, mem_wdata, mem_rdata, load_data;
  logic [3:0]  mem_be;

  int total = 0, bad = 0;
  int req_cnt = 0;
  logic [7:0] mem_b [64];
  logic [7:0] ref_b [64];

  always #5 clk = ~clk;

  mla_top u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_addr_i(req_addr), .req_size_i(req_size), .req_signed_i(req_signed),
    .req_write_i(req_write), .req_wdata_i(req_wdata), .mode_i(mode),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_we_o(mem_we),
    .mem_be_o(mem_be), .mem_wdata_o(mem_wdata),
    .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata),
    .done_o(done), .fault_o(fault), .load_data_o(load_data)
  );

  // memory model: 64 bytes, one outstanding request, 1..3 cycle response
  logic        pend = 1'b0;
  int          wcnt = 0;
  logic [31:0] pdata = '0;
  always @(posedge clk) begin
    mem_rvalid <= 1'b0;
    if (!rst_n) begin
      pend = 1'b0;
    end else if (mem_req) begin
      req_cnt++;
      for (int i = 0; i < 4; i++) begin
        pdata[8*i +: 8] = mem_b[{mem_addr[5:2], 2'(i)}];
        if (mem_we && mem_be[i]) mem_b[{mem_addr[5:2], 2'(i)}] = mem_wdata[8*i +: 8];
      end
      wcnt = $urandom_range(0, 2);
      pend = 1'b1;
    end else if (pend) begin
      if (wcnt == 0) begin
        mem_rvalid <= 1'b1;
        mem_rdata  <= pdata;
        pend = 1'b0;
      end else wcnt--;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic access(input logic [5:0] a, input logic [1:0] sz, input bit sg,
                        input bit wr, input logic [31:0] wd, input logic [1:0] md,
                        input string tag);
    int nb, ea, exp_reqs, n;
    bit mis, flt, rv_prev, mem_ok;
    logic [31:0] ev;
    nb  = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    mis = (int'(a) % nb) != 0;
    flt = (md == 2'd1) && mis;
    ea  = (md != 2'd2 && mis) ? (int'(a) & ~(nb - 1)) : int'(a);
    exp_reqs = flt ? 0 : (((ea % 4) + nb) > 4 ? 2 : 1);
    ev = '0;
    for (int i = 0; i < nb; i++) ev[8*i +: 8] = ref_b[(ea + i) % 64];
    if (sz == 2'd0 && sg) ev = {{24{ev[7]}}, ev[7:0]};
    if (sz == 2'd1 && sg) ev = {{16{ev[15]}}, ev[15:0]};
    if (wr && !flt)
      for (int i = 0; i < nb; i++) ref_b[(ea + i) % 64] = wd[8*i +: 8];

    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_cnt = 0;
    req_valid = 1'b1; req_addr = {26'd0, a}; req_size = sz; req_signed = sg;
    req_write = wr; req_wdata = wd; mode = md;
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready, {"R8 busy ", tag}, 32'(req_ready), 32'd0);
    n = 0; rv_prev = 1'b0;
    while (!done && n < 50) begin
      rv_prev = mem_rvalid;
      @(negedge clk);
      n++;
    end
    chk(done, {"R7 done seen ", tag}, 32'(done), 32'd1);
    if (flt) chk(n == 0, {"R7 fault done timing ", tag}, 32'(n), 32'd0);
    else     chk(rv_prev, {"R7 done after response ", tag}, 32'(rv_prev), 32'd1);
    chk(fault == flt, {"R2 fault ", tag}, 32'(fault), 32'(flt));
    chk(req_cnt == exp_reqs, {"R3 request count ", tag}, 32'(req_cnt), 32'(exp_reqs));
    if (!wr && !flt) chk(load_data == ev, {"R4 R5 load data ", tag}, load_data, ev);
    if (wr) begin
      mem_ok = 1'b1;
      for (int i = 0; i < 64; i++) if (mem_b[i] !== ref_b[i]) mem_ok = 1'b0;
      chk(mem_ok, {"R6 memory image ", tag}, {26'd0, a}, 32'(ea));
    end
    chk(!req_ready, {"R8 busy in done ", tag}, 32'(req_ready), 32'd0);
    @(negedge clk);
    chk(req_ready && !done, {"R8 R7 back to idle ", tag}, {30'd0, req_ready, done}, 32'd2);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 64; i++) begin
      mem_b[i] = 8'($urandom);
      ref_b[i] = mem_b[i];
    end
    mem_b[8] = 8'h80; ref_b[8] = 8'h80;
    mem_b[9] = 8'hF1; ref_b[9] = 8'hF1;
    repeat (3) @(negedge clk);
    chk(req_ready && !mem_req && !done && !fault, "R10 reset state",
        {28'd0, req_ready, mem_req, done, fault}, 32'h8);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !mem_req && !done && !fault, "R10 after reset",
        {28'd0, req_ready, mem_req, done, fault}, 32'h8);

    access(6'd8,  2'd2, 1'b0, 1'b0, '0, 2'd0, "R4 aligned word");
    access(6'd8,  2'd0, 1'b0, 1'b0, '0, 2'd0, "R5 byte zero ext");
    access(6'd8,  2'd0, 1'b1, 1'b0, '0, 2'd0, "R5 byte sign ext");
    access(6'd8,  2'd1, 1'b1, 1'b0, '0, 2'd0, "R5 half sign ext");
    access(6'd8,  2'd2, 1'b1, 1'b0, '0, 2'd0, "R5 word flag ignored");
    access(6'd9,  2'd1, 1'b1, 1'b0, '0, 2'd0, "R1 truncate half");
    access(6'd11, 2'd3, 1'b0, 1'b0, '0, 2'd3, "R1 spare mode truncate word");
    access(6'd10, 2'd2, 1'b0, 1'b0, '0, 2'd1, "R2 fault word");
    access(6'd13, 2'd1, 1'b0, 1'b1, 32'hDEAD_BEEF, 2'd1, "R2 fault store no write");
    access(6'd12, 2'd2, 1'b0, 1'b0, '0, 2'd1, "R2 aligned in fault mode");
    access(6'd5,  2'd1, 1'b1, 1'b0, '0, 2'd2, "R3 half inside word");
    access(6'd7,  2'd1, 1'b0, 1'b0, '0, 2'd2, "R3 half split");
    access(6'd9,  2'd2, 1'b0, 1'b0, '0, 2'd2, "R3 word split");
    access(6'd62, 2'd2, 1'b0, 1'b0, '0, 2'd2, "R3 split wrap");
    access(6'd19, 2'd2, 1'b0, 1'b1, 32'h1122_3344, 2'd2, "R6 split store");
    access(6'd21, 2'd0, 1'b0, 1'b1, 32'hFFFF_FFA5, 2'd0, "R6 byte store");
    access(6'd19, 2'd2, 1'b0, 1'b0, '0, 2'd2, "R4 read back split");

    for (int k = 0; k < 400; k++)
      access(6'($urandom), 2'($urandom), 1'($urandom), 1'($urandom),
             $urandom, 2'($urandom), "random");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #2000000;
    bad++; total++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule